// File: doc/BRIEF.md
# Card Host Controller Register Bank

This block is the register file that sits between a processor bus and the command and data engines of a memory-card host controller. It keeps the configuration words those engines consume: power and clock settings, the command argument and command word, the data timeout, the transfer length and the data control byte. It shows them on output ports and reads them back over a 32-bit bus with a 12-bit byte address.

The engines report events by pulsing bits of a 22-bit set input. Each pulse sets a sticky bit in the status register. Software clears the lower eleven of those bits by writing ones to a clear port. Two independent mask registers are each ANDed with status, and each drives its own interrupt line. The block also shows a fixed eight-byte identification sequence, one byte per word, at the top of the address space. It passes accesses to the FIFO window through to the external data engine, with a guard against empty reads and against writes when no transfer is pending.

Top module: `sdr_hostreg_top`

## Requirements
- R1: After a synchronous reset, every register reads back zero and both interrupt lines are low.
- R2: Power (0x00) and clock (0x04) keep only bits 7:0 of a write, and read back zero above that.
- R3: Argument (0x08), command (0x0C) and data timer (0x24) keep all 32 bits. Data length (0x28) keeps bits 15:0. Data control (0x2C) keeps bits 7:0.
- R4: A read of 0x30 returns the external transfer count in bits 15:0, with zero above.
- R5: A 1 on bit k of the event input in a cycle sets status bit k (0x34) at the next clock edge. The bit stays set until it is cleared.
- R6: A write to 0x38 clears each status bit in 10:0 whose written bit is 1. Status bits 21:11 are never changed by it.
- R7: When an event pulse and a clear hit the same status bit in one cycle, the bit ends up set.
- R8: Mask 0 (0x3C) and mask 1 (0x40) are 32-bit registers. Interrupt line i (irq_line[i]) is high exactly when status AND mask i is nonzero.
- R9: Reads of 0xFE0, 0xFE4, ... 0xFFC return, in that address order, 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0.
- R10: A read in 0x80–0xBF returns fifo_rdata and pulses fifo_pop when fifo_empty is low. When fifo_empty is high, the read returns zero and fifo_pop stays low.
- R11: A write in 0x80–0xBF pulses fifo_push with fifo_wdata equal to the written word when the transfer count is nonzero. When the count is zero, fifo_push stays low.
- R12: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| evt_set | input | 22 | Status set pulses from the engines |
| xfer_count | input | 16 | Remaining transfer count from the data engine |
| fifo_empty | input | 1 | Data FIFO has no word to give |
| fifo_rdata | input | 32 | Head word of the data FIFO |
| fifo_pop | output | 1 | Take the head word |
| fifo_push | output | 1 | Store fifo_wdata |
| fifo_wdata | output | 32 | Word to store |
| cfg_power | output | 8 | Power setting |
| cfg_clock | output | 8 | Clock setting |
| cmd_arg | output | 32 | Command argument |
| cmd_word | output | 32 | Command word |
| data_timer | output | 32 | Data timeout |
| data_len | output | 16 | Transfer length |
| data_ctrl | output | 8 | Data control byte |
| irq_line | output | 2 | Interrupt lines 0 and 1 |

## Verification
An engine event pulse and a software clear of the status register can land in the same cycle. The bench provokes this by driving a set pulse on one low status bit while it writes all ones to the clear port. It then reads status back and expects the pulsed bit still set, while the other cleared low bits read zero and the high bits are untouched. A second collision pairs a clear with an interrupt mask. Lowering a masked bit through the clear port must drop only the line whose mask selects that bit.

// File: rtl/sdr_regbank_pkg.sv
// Package: shared widths, register offsets and the identification sequence
// for the card host controller register bank.
// Assumes byte addressing with word-aligned register offsets.
package sdr_regbank_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int STAT_W = 22;
    localparam int CLR_W  = 11;
    localparam int N_IRQ  = 2;
    localparam int ID_N   = 8;

    localparam logic [11:0] OFS_POWER = 12'h000;
    localparam logic [11:0] OFS_CLOCK = 12'h004;
    localparam logic [11:0] OFS_ARG   = 12'h008;
    localparam logic [11:0] OFS_CMD   = 12'h00C;
    localparam logic [11:0] OFS_TIMER = 12'h024;
    localparam logic [11:0] OFS_LEN   = 12'h028;
    localparam logic [11:0] OFS_DCTRL = 12'h02C;
    localparam logic [11:0] OFS_COUNT = 12'h030;
    localparam logic [11:0] OFS_STAT  = 12'h034;
    localparam logic [11:0] OFS_CLR   = 12'h038;
    localparam logic [11:0] OFS_MASK0 = 12'h03C;
    localparam logic [11:0] OFS_ID    = 12'hFE0;

    // Fixed identification byte for word index idx of the ID window.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h81;
            3'd1:    id_byte = 8'h11;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/sdr_cfg_regs.sv
// Module: configuration registers written over the bus (power, clock,
// argument, command, data timer, data length, data control).
// Assumes a single write strobe with full-word data and no byte enables.
module sdr_cfg_regs
    import sdr_regbank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int LEN_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [BYTE_W-1:0] power_q,
    output logic [BYTE_W-1:0] clock_q,
    output logic [DW-1:0]     arg_q,
    output logic [DW-1:0]     cmd_q,
    output logic [DW-1:0]     timer_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [BYTE_W-1:0] dctrl_q
);

    // Load the addressed register on a write; all clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            power_q <= '0;
            clock_q <= '0;
            arg_q   <= '0;
            cmd_q   <= '0;
            timer_q <= '0;
            len_q   <= '0;
            dctrl_q <= '0;
        end else if (wr) begin
            case (addr)
                AW'(OFS_POWER): power_q <= wdata[BYTE_W-1:0];
                AW'(OFS_CLOCK): clock_q <= wdata[BYTE_W-1:0];
                AW'(OFS_ARG):   arg_q   <= wdata;
                AW'(OFS_CMD):   cmd_q   <= wdata;
                AW'(OFS_TIMER): timer_q <= wdata;
                AW'(OFS_LEN):   len_q   <= wdata[LEN_W-1:0];
                AW'(OFS_DCTRL): dctrl_q <= wdata[BYTE_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdr_status_irq.sv
// Module: sticky status register with set pulses and a partial clear port,
// plus N_MSK mask registers, each producing one interrupt line.
// Assumes set pulses win over a clear of the same bit in the same cycle.
module sdr_status_irq
    import sdr_regbank_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter int CW = CLR_W,
    parameter int DW = DATA_W,
    parameter int N_MSK = N_IRQ
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SW-1:0]             evt_set,
    input  logic                      clr_we,
    input  logic [N_MSK-1:0]          mask_we,
    input  logic [DW-1:0]             wdata,
    output logic [SW-1:0]             status_q,
    output logic [N_MSK-1:0][DW-1:0]  mask_q,
    output logic [N_MSK-1:0]          irq
);

    logic [SW-1:0] clr_vec;

    // Clear vector: only the low CW bits may be cleared by software.
    always_comb begin
        clr_vec = '0;
        if (clr_we) clr_vec[CW-1:0] = wdata[CW-1:0];
    end

    // Status update: clear first, then OR in the event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | evt_set;
    end

    for (genvar i = 0; i < N_MSK; i++) begin : g_mask
        // Mask register i, loaded by its own write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)          mask_q[i] <= '0;
            else if (mask_we[i]) mask_q[i] <= wdata;
        end
        // Interrupt line i: any status bit selected by mask i.
        always_comb irq[i] = |(status_q & mask_q[i][SW-1:0]);
    end

endmodule

// File: rtl/sdr_read_mux.sv
// Module: combinational read data selection across all mapped offsets,
// the identification window and the FIFO window.
// Assumes unmapped offsets read as zero and no read returns data when idle.
module sdr_read_mux
    import sdr_regbank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = STAT_W,
    parameter int LEN_W = 16,
    parameter int BYTE_W = 8,
    parameter int N_MSK = N_IRQ
) (
    input  logic                     rd,
    input  logic [AW-1:0]            addr,
    input  logic [BYTE_W-1:0]        power_q,
    input  logic [BYTE_W-1:0]        clock_q,
    input  logic [DW-1:0]            arg_q,
    input  logic [DW-1:0]            cmd_q,
    input  logic [DW-1:0]            timer_q,
    input  logic [LEN_W-1:0]         len_q,
    input  logic [BYTE_W-1:0]        dctrl_q,
    input  logic [LEN_W-1:0]         xfer_count,
    input  logic [SW-1:0]            status_q,
    input  logic [N_MSK-1:0][DW-1:0] mask_q,
    input  logic                     fifo_win,
    input  logic                     fifo_empty,
    input  logic [DW-1:0]            fifo_rdata,
    output logic [DW-1:0]            rdata
);

    localparam logic [AW-1:0] ID_BASE = AW'(OFS_ID);

    // Select the word addressed by a read; zero for anything unmapped.
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr >= ID_BASE) begin
                rdata = DW'(id_byte(addr[4:2]));
            end else if (fifo_win) begin
                if (!fifo_empty) rdata = fifo_rdata;
            end else begin
                case (addr)
                    AW'(OFS_POWER): rdata = DW'(power_q);
                    AW'(OFS_CLOCK): rdata = DW'(clock_q);
                    AW'(OFS_ARG):   rdata = arg_q;
                    AW'(OFS_CMD):   rdata = cmd_q;
                    AW'(OFS_TIMER): rdata = timer_q;
                    AW'(OFS_LEN):   rdata = DW'(len_q);
                    AW'(OFS_DCTRL): rdata = DW'(dctrl_q);
                    AW'(OFS_COUNT): rdata = DW'(xfer_count);
                    AW'(OFS_STAT):  rdata = DW'(status_q);
                    default: begin
                        for (int m = 0; m < N_MSK; m++)
                            if (addr == AW'(OFS_MASK0) + AW'(4 * m))
                                rdata = mask_q[m];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sdr_hostreg_top.sv
// Module: top of the card host controller register bank. Decodes the bus,
// holds configuration, status and masks, drives two interrupt lines and
// guards accesses to the external data FIFO.
// Assumes bus_wr and bus_rd are never high together.
module sdr_hostreg_top
    import sdr_regbank_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [11:0]  bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    input  logic [21:0]  evt_set,
    input  logic [15:0]  xfer_count,
    input  logic         fifo_empty,
    input  logic [31:0]  fifo_rdata,
    output logic         fifo_pop,
    output logic         fifo_push,
    output logic [31:0]  fifo_wdata,
    output logic [7:0]   cfg_power,
    output logic [7:0]   cfg_clock,
    output logic [31:0]  cmd_arg,
    output logic [31:0]  cmd_word,
    output logic [31:0]  data_timer,
    output logic [15:0]  data_len,
    output logic [7:0]   data_ctrl,
    output logic [1:0]   irq_line
);

    localparam int LEN_W  = 16;
    localparam int BYTE_W = 8;

    logic [STAT_W-1:0]            status_q;
    logic [N_IRQ-1:0][DATA_W-1:0] mask_q;
    logic                         clr_we;
    logic [N_IRQ-1:0]             mask_we;
    logic                         fifo_win;

    // Decode strobes for the clear port, the masks and the FIFO window.
    always_comb begin
        clr_we   = bus_wr && (bus_addr == OFS_CLR);
        fifo_win = (bus_addr[11:6] == 6'b000010);
        for (int m = 0; m < N_IRQ; m++)
            mask_we[m] = bus_wr && (bus_addr == OFS_MASK0 + 12'(4 * m));
    end

    // FIFO pass-through with empty and zero-count guards.
    always_comb begin
        fifo_pop   = bus_rd && fifo_win && !fifo_empty;
        fifo_push  = bus_wr && fifo_win && (xfer_count != '0);
        fifo_wdata = bus_wdata;
    end

    sdr_cfg_regs #(
        .AW(ADDR_W), .DW(DATA_W), .LEN_W(LEN_W), .BYTE_W(BYTE_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .power_q(cfg_power), .clock_q(cfg_clock),
        .arg_q(cmd_arg), .cmd_q(cmd_word), .timer_q(data_timer),
        .len_q(data_len), .dctrl_q(data_ctrl)
    );

    sdr_status_irq #(
        .SW(STAT_W), .CW(CLR_W), .DW(DATA_W), .N_MSK(N_IRQ)
    ) stat_i (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .clr_we(clr_we),
        .mask_we(mask_we), .wdata(bus_wdata), .status_q(status_q),
        .mask_q(mask_q), .irq(irq_line)
    );

    sdr_read_mux #(
        .AW(ADDR_W), .DW(DATA_W), .SW(STAT_W), .LEN_W(LEN_W),
        .BYTE_W(BYTE_W), .N_MSK(N_IRQ)
    ) rmux_i (
        .rd(bus_rd), .addr(bus_addr), .power_q(cfg_power),
        .clock_q(cfg_clock), .arg_q(cmd_arg), .cmd_q(cmd_word),
        .timer_q(data_timer), .len_q(data_len), .dctrl_q(data_ctrl),
        .xfer_count(xfer_count), .status_q(status_q), .mask_q(mask_q),
        .fifo_win(fifo_win), .fifo_empty(fifo_empty),
        .fifo_rdata(fifo_rdata), .rdata(bus_rdata)
    );

endmodule

// File: rtl/sdr_hostreg_chk.sv
// Module: property checker for the register bank, bound to the top.
// Assumes it sees the top's internal status register through the bind.
module sdr_hostreg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [21:0] evt_set,
    input logic [15:0] xfer_count,
    input logic        fifo_empty,
    input logic        fifo_pop,
    input logic        fifo_push,
    input logic [1:0]  irq_line,
    input logic [21:0] status_q
);

    // R5 and R7: every pulsed bit is set one edge later, even under a clear.
    a_r5_pulse_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((status_q & $past(evt_set)) == $past(evt_set)));

    // R6: the clear port never lowers bits 21:11.
    a_r6_high_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h038) |=>
        ((status_q[21:11] & $past(status_q[21:11])) == $past(status_q[21:11])));

    // R8: with no status bit set, neither line may be raised.
    a_r8_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> (irq_line == 2'b00));

    // R10: a pop only on a read with data available.
    a_r10_pop_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (bus_rd && !fifo_empty));

    // R11: a push only on a write while a transfer is pending.
    a_r11_push_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (bus_wr && xfer_count != '0));

endmodule

bind sdr_hostreg_top sdr_hostreg_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .evt_set(evt_set), .xfer_count(xfer_count),
    .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .fifo_push(fifo_push),
    .irq_line(irq_line), .status_q(status_q)
);

// File: tb/sdr_hostreg_top_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard. Read tasks queue expected words; a monitor compares
// bus_rdata against the queue head while the read is on the bus.
module sdr_hostreg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [21:0] evt_set = '0;
    logic [15:0] xfer_count = '0;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_rdata = '0;
    logic        fifo_pop, fifo_push;
    logic [31:0] fifo_wdata;
    logic [7:0]  cfg_power, cfg_clock, data_ctrl;
    logic [31:0] cmd_arg, cmd_word, data_timer;
    logic [15:0] data_len;
    logic [1:0]  irq_line;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    sdr_hostreg_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_set(evt_set), .xfer_count(xfer_count), .fifo_empty(fifo_empty),
        .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .cfg_power(cfg_power), .cfg_clock(cfg_clock),
        .cmd_arg(cmd_arg), .cmd_word(cmd_word), .data_timer(data_timer),
        .data_len(data_len), .data_ctrl(data_ctrl), .irq_line(irq_line)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Monitor: compare each read cycle with the scoreboard head.
    always @(negedge clk) begin
        #1;
        if (bus_rd) begin
            if (exp_q.size() == 0) check("scoreboard-empty", 32'h1, 32'h0);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(logic [21:0] bits);
        @(negedge clk);
        evt_set = bits;
        @(negedge clk);
        evt_set = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [7:0] id_exp [8] = '{8'h81, 8'h11, 8'h04, 8'h00,
                                   8'h0D, 8'hF0, 8'h05, 8'hB1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(12'h034, 32'h0, "R1 status");
        bus_read(12'h03C, 32'h0, "R1 mask0");
        bus_read(12'h000, 32'h0, "R1 power");
        bus_read(12'h028, 32'h0, "R1 length");
        check("R1 irq", {30'b0, irq_line}, 32'h0);

        // R2: byte-wide registers
        bus_write(12'h000, 32'hFFFF_FFA5);
        bus_read(12'h000, 32'h0000_00A5, "R2 power");
        bus_write(12'h004, 32'h0000_1234);
        bus_read(12'h004, 32'h0000_0034, "R2 clock");

        // R3: widths of the other configuration registers
        bus_write(12'h008, 32'hDEAD_BEEF);
        bus_write(12'h00C, 32'h0000_0455);
        bus_write(12'h024, 32'h1234_5678);
        bus_write(12'h028, 32'hABCD_1234);
        bus_write(12'h02C, 32'h0000_01FF);
        bus_read(12'h008, 32'hDEAD_BEEF, "R3 arg");
        bus_read(12'h00C, 32'h0000_0455, "R3 cmd");
        bus_read(12'h024, 32'h1234_5678, "R3 timer");
        bus_read(12'h028, 32'h0000_1234, "R3 length");
        bus_read(12'h02C, 32'h0000_00FF, "R3 dctrl");
        check("R3 data_len port", {16'b0, data_len}, 32'h1234);

        // R4: transfer count mirror
        xfer_count = 16'h0040;
        bus_read(12'h030, 32'h0000_0040, "R4 count");

        // R5: sticky event bits
        pulse(22'h001021);
        bus_read(12'h034, 32'h0000_1021, "R5 status");
        bus_read(12'h034, 32'h0000_1021, "R5 sticky");

        // R6: clear only reaches bits 10:0
        bus_write(12'h038, 32'hFFFF_FFFF);
        bus_read(12'h034, 32'h0000_1000, "R6 partial clear");

        // R7: set beats clear on the same bit
        pulse(22'h008004);
        @(negedge clk);
        bus_addr = 12'h038; bus_wdata = 32'h0000_07FF; bus_wr = 1'b1;
        evt_set = 22'h000004;
        @(negedge clk);
        bus_wr = 1'b0; evt_set = '0;
        bus_read(12'h034, 32'h0000_9004, "R7 collision");

        // R8: two independent masks
        bus_write(12'h03C, 32'h0000_8000);
        bus_write(12'h040, 32'h0000_0002);
        #1 check("R8 lines mask0 only", {30'b0, irq_line}, 32'h1);
        pulse(22'h000002);
        #1 check("R8 line1 raised", {30'b0, irq_line}, 32'h3);
        bus_write(12'h038, 32'h0000_0002);
        #1 check("R8 line1 dropped", {30'b0, irq_line}, 32'h1);
        bus_write(12'h03C, 32'h0);
        #1 check("R8 mask0 cleared", {30'b0, irq_line}, 32'h0);
        bus_read(12'h040, 32'h0000_0002, "R8 mask1 readback");

        // R9: identification window
        for (int k = 0; k < 8; k++)
            bus_read(12'hFE0 + 12'(4 * k), {24'b0, id_exp[k]}, "R9 id");

        // R10: FIFO reads
        fifo_empty = 1'b0; fifo_rdata = 32'hCAFE_F00D;
        @(negedge clk);
        bus_addr = 12'h084; bus_rd = 1'b1;
        exp_q.push_back(32'hCAFE_F00D); tag_q.push_back("R10 data");
        #2 check("R10 pop", {31'b0, fifo_pop}, 32'h1);
        @(negedge clk);
        bus_rd = 1'b0; fifo_empty = 1'b1;
        @(negedge clk);
        bus_addr = 12'h0B0; bus_rd = 1'b1;
        exp_q.push_back(32'h0); tag_q.push_back("R10 empty data");
        #2 check("R10 no pop", {31'b0, fifo_pop}, 32'h0);
        @(negedge clk);
        bus_rd = 1'b0;

        // R11: FIFO writes
        @(negedge clk);
        bus_addr = 12'h0BC; bus_wdata = 32'h0000_55AA; bus_wr = 1'b1;
        #1 check("R11 push", {31'b0, fifo_push}, 32'h1);
        check("R11 wdata", fifo_wdata, 32'h0000_55AA);
        @(negedge clk);
        bus_wr = 1'b0; xfer_count = '0;
        @(negedge clk);
        bus_addr = 12'h080; bus_wdata = 32'h1; bus_wr = 1'b1;
        #1 check("R11 no push", {31'b0, fifo_push}, 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;

        // R12: unmapped offsets
        bus_write(12'h044, 32'hFFFF_FFFF);
        bus_read(12'h044, 32'h0, "R12 unmapped read");
        bus_read(12'h014, 32'h0, "R12 gap read");
        bus_write(12'h200, 32'hFFFF_FFFF);
        bus_read(12'h034, 32'h0000_9004, "R12 status untouched");
        bus_read(12'h040, 32'h0000_0002, "R12 mask1 untouched");
        bus_read(12'h000, 32'h0000_00A5, "R12 power untouched");

        repeat (2) @(negedge clk);
        check("scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule